// File: doc/BRIEF.md
# Prioritized Trap Selection Arbiter

This block sits beside one pipeline stage of a processor. It receives a vector of pending exception and interrupt requests, one bit per trap kind, and picks the single trap to take this cycle. A fixed internal table gives each trap kind a 9-bit trap-type code, a priority number and a handling level for each current execution mode. The smallest priority number wins. Several trap kinds share a priority number, and among those the smallest trap-type code wins.

The block reports four things: whether any trap was selected, the winner's trap type, its priority number, and whether the trap must be handled at the hyperprivileged level or at the privileged level. The handling level is found from the winner's table row and the current mode. The selection logic is a combinational compare tree. A parameter adds an optional output register, which is present by default. The logic that raises the requests and the handler entry sequence live elsewhere.

Top module: `trap_select_arb`

## Requirements
- R1: `valid_o` is 1 exactly when at least one bit of `req_i` was set in the selected input cycle.
- R2: When no request is pending, `valid_o`, `ttype_o`, `prio_o` and `hyper_o` are all zero.
- R3: Among the pending requests, the one whose table priority number is smallest is reported on `ttype_o` and `prio_o`.
- R4: When pending requests share the smallest priority number, the one with the smallest trap-type code wins. Examples: clean window (0x024) beats the misaligned floating-point traps (0x035..0x039), and spill normal (0x080) beats the other spill and fill traps.
- R5: Each request bit index maps to a fixed row, written as bit: type/priority. 0: 0x001/0, 1: 0x002/120, 2: 0x003/110, 3: 0x004/130, 4: 0x010/620, 5: 0x011/700, 6: 0x020/800, 7: 0x024/1010, 8: 0x035/1010, 9: 0x036/1010, 10: 0x038/1010, 11: 0x039/1010, 12: 0x041/1600, 13: 0x080/900, 14: 0x0A0/900, 15: 0x0C0/900, 16: 0x0E0/900, 17: 0x100/1602.
- R6: The reset-class traps are ordered as follows: power-on (bit 0) beats everything, then external (bit 2), then watchdog (bit 1), then software (bit 3).
- R7: `hyper_o` gives the handling level, where 1 means hyperprivileged and 0 means privileged. From hyperprivileged mode, every trap is handled hyperprivileged. From user mode, bits 5, 6, 7, 12, 13, 14, 15, 16 and 17 are handled privileged. From privileged mode, the same set minus bit 5 is handled privileged. All other bits are handled hyperprivileged.
- R8: `mode_i` encodes 0 as user, 1 as privileged and 2 as hyperprivileged. Code 3 is treated as hyperprivileged.
- R9: With `REG_OUT`=1, the outputs show the result of the inputs present at the previous rising clock edge and stay unchanged between edges. While `rst_ni` is low, the outputs are forced to zero without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 18 | Pending trap requests, one bit per table row |
| mode_i | input | 2 | Current execution mode |
| valid_o | output | 1 | A trap was selected |
| ttype_o | output | 9 | Trap-type code of the winner |
| prio_o | output | 12 | Priority number of the winner |
| hyper_o | output | 1 | Winner must be handled at hyperprivileged level |

## Verification
On every cycle, the assertions check the following: the valid flag tracks the OR of the requests, the winner's request bit is set, no pending row holds a smaller priority and type key than the winner, the hyperprivileged mode always yields hyperprivileged handling, and the idle result stays all-zero. The assertions also check that the register stage delays its input by one cycle. The bench's scenarios are needed to show the actual table contents: exact codes and priority numbers, the specific tie pairs, the reset-class order, and the per-mode level pattern for individual traps. The same holds for the timing of the outputs relative to input changes and to an asynchronous reset.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;

  localparam int NUM_TRAPS = 18;
  localparam int TT_W      = 9;
  localparam int PRIO_W    = 12;
  localparam int IDX_W     = $clog2(NUM_TRAPS);
  localparam int NUM_MODES = 3;
  localparam int KEY_W     = PRIO_W + TT_W;

  // handling-level mask: bit m set => hyperprivileged when current mode column is m
  localparam logic [NUM_MODES-1:0] LV_HHH = 3'b111;
  localparam logic [NUM_MODES-1:0] LV_PHH = 3'b110;
  localparam logic [NUM_MODES-1:0] LV_PPH = 3'b100;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [TT_W-1:0]   ttype;
    logic [PRIO_W-1:0] prio;
  } trap_cand_t;

  typedef struct packed {
    logic              valid;
    logic [TT_W-1:0]   ttype;
    logic [PRIO_W-1:0] prio;
    logic              hyper;
  } trap_result_t;

  function automatic logic [TT_W-1:0] row_ttype(input int unsigned idx);
    case (idx)
      0:  return 9'h001;
      1:  return 9'h002;
      2:  return 9'h003;
      3:  return 9'h004;
      4:  return 9'h010;
      5:  return 9'h011;
      6:  return 9'h020;
      7:  return 9'h024;
      8:  return 9'h035;
      9:  return 9'h036;
      10: return 9'h038;
      11: return 9'h039;
      12: return 9'h041;
      13: return 9'h080;
      14: return 9'h0A0;
      15: return 9'h0C0;
      16: return 9'h0E0;
      17: return 9'h100;
      default: return '0;
    endcase
  endfunction

  function automatic logic [PRIO_W-1:0] row_prio(input int unsigned idx);
    case (idx)
      0:  return 12'd0;
      1:  return 12'd120;
      2:  return 12'd110;
      3:  return 12'd130;
      4:  return 12'd620;
      5:  return 12'd700;
      6:  return 12'd800;
      7, 8, 9, 10, 11: return 12'd1010;
      12: return 12'd1600;
      13, 14, 15, 16:  return 12'd900;
      17: return 12'd1602;
      default: return '1;
    endcase
  endfunction

  function automatic logic [NUM_MODES-1:0] row_hmask(input int unsigned idx);
    case (idx)
      5:                              return LV_PHH;
      6, 7, 12, 13, 14, 15, 16, 17:   return LV_PPH;
      default:                        return LV_HHH;
    endcase
  endfunction

  // mode code to table column: 0 user, 1 privileged, 2 and 3 hyperprivileged
  function automatic int unsigned mode_col(input logic [1:0] mode);
    case (mode)
      2'd0:    return 0;
      2'd1:    return 1;
      default: return 2;
    endcase
  endfunction

  function automatic trap_cand_t mk_cand(input logic v, input int unsigned idx);
    trap_cand_t c;
    c.valid = v;
    c.idx   = IDX_W'(idx);
    c.ttype = row_ttype(idx);
    c.prio  = row_prio(idx);
    return c;
  endfunction

  function automatic logic [KEY_W-1:0] cand_key(input trap_cand_t c);
    return {c.prio, c.ttype};
  endfunction

  // a wins over b when valid and its (priority, type) key is not larger
  function automatic logic a_beats_b(input trap_cand_t a, input trap_cand_t b);
    return a.valid && (!b.valid || (cand_key(a) <= cand_key(b)));
  endfunction

endpackage

// File: rtl/trap_pair_pick.sv
module trap_pair_pick
  import trap_arb_pkg::*;
(
  input  trap_cand_t a_i,
  input  trap_cand_t b_i,
  output trap_cand_t win_o
);
  logic take_a;
  assign take_a = a_beats_b(a_i, b_i);
  assign win_o  = take_a ? a_i : b_i;
endmodule

// File: rtl/trap_pick_tree.sv
module trap_pick_tree
  import trap_arb_pkg::*;
#(
  parameter int N = NUM_TRAPS
) (
  input  logic [N-1:0] req_i,
  output trap_cand_t   win_o
);
  localparam int LVL = (N > 1) ? $clog2(N) : 1;
  localparam int SZ  = 1 << LVL;

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int W = SZ >> l;
    trap_cand_t c [W];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_i
        if (i < N) begin : g_real
          assign c[i] = mk_cand(req_i[i], i);
        end else begin : g_pad
          assign c[i] = '0;
        end
      end
    end else begin : g_node
      for (genvar i = 0; i < W; i++) begin : g_i
        trap_pair_pick u_pick (
          .a_i  (g_lvl[l-1].c[2*i]),
          .b_i  (g_lvl[l-1].c[2*i+1]),
          .win_o(c[i])
        );
      end
    end
  end

  assign win_o = g_lvl[LVL].c[0];
endmodule

// File: rtl/trap_level_map.sv
module trap_level_map
  import trap_arb_pkg::*;
(
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       mode_i,
  output logic             hyper_o
);
  logic [NUM_MODES-1:0] hmask;
  assign hmask   = row_hmask(32'(idx_i));
  assign hyper_o = valid_i & hmask[mode_col(mode_i)];
endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage #(
  parameter bit REG_OUT = 1'b1,
  parameter int W       = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    logic [W-1:0] q_r;
    logic         primed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q_r      <= '0;
        primed_q <= 1'b0;
      end else begin
        q_r      <= d_i;
        primed_q <= 1'b1;
      end
    end
    assign q_o = q_r;

    // R9: output carries the input of the previous edge
    p_one_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      primed_q |-> (q_o == $past(d_i)))
      else $error("p_one_cycle_r9");
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/trap_select_arb.sv
module trap_select_arb
  import trap_arb_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_TRAPS-1:0] req_i,
  input  logic [1:0]        mode_i,
  output logic              valid_o,
  output logic [TT_W-1:0]   ttype_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic              hyper_o
);
  localparam int RES_W = $bits(trap_result_t);

  trap_cand_t   win;
  logic         win_hyper;
  trap_result_t res_comb;
  trap_result_t res_q;

  trap_pick_tree #(.N(NUM_TRAPS)) u_tree (
    .req_i(req_i),
    .win_o(win)
  );

  trap_level_map u_level (
    .valid_i(win.valid),
    .idx_i  (win.idx),
    .mode_i (mode_i),
    .hyper_o(win_hyper)
  );

  always_comb begin
    res_comb       = '0;
    res_comb.valid = win.valid;
    if (win.valid) begin
      res_comb.ttype = win.ttype;
      res_comb.prio  = win.prio;
      res_comb.hyper = win_hyper;
    end
  end

  trap_out_stage #(.REG_OUT(REG_OUT), .W(RES_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (res_comb),
    .q_o   (res_q)
  );

  assign valid_o = res_q.valid;
  assign ttype_o = res_q.ttype;
  assign prio_o  = res_q.prio;
  assign hyper_o = res_q.hyper;

  // R1: tree reports a winner exactly when something is pending
  p_valid_any_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win.valid == (|req_i))
    else $error("p_valid_any_r1");

  // R3: the winner really is pending
  p_winner_pending_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win.valid |-> req_i[win.idx])
    else $error("p_winner_pending_r3");

  // R3/R4: no pending row has a smaller (priority, type) key than the winner
  for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_minchk
    p_min_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[i] |-> (cand_key(mk_cand(1'b1, i)) >= cand_key(win)))
      else $error("p_min_key_r4");
  end

  // R7: hyperprivileged mode always handles traps hyperprivileged
  p_hyper_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win.valid && mode_i[1]) |-> win_hyper)
    else $error("p_hyper_mode_r7");

  // R2: an idle result is all-zero at the ports
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (ttype_o == '0 && prio_o == '0 && !hyper_o))
    else $error("p_idle_zero_r2");
endmodule

// File: tb/test_trap_select_arb.sv
module test_trap_select_arb;
  import trap_arb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NT = NUM_TRAPS;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] req_i = '0;
  logic [1:0]    mode_i = 2'd0;
  logic          valid_o;
  logic [8:0]    ttype_o;
  logic [11:0]   prio_o;
  logic          hyper_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [8:0]  b_tt [NT];
  logic [11:0] b_pr [NT];
  logic        b_priv_user [NT];
  logic        b_priv_sup  [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_select_arb i_trap_select_arb (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .mode_i(mode_i),
    .valid_o(valid_o), .ttype_o(ttype_o), .prio_o(prio_o), .hyper_o(hyper_o)
  );

  function automatic logic [22:0] expect_of(input logic [NT-1:0] r, input logic [1:0] m);
    logic found = 1'b0;
    int   best = 0;
    logic hy;
    for (int i = 0; i < NT; i++) begin
      if (r[i]) begin
        if (!found || b_pr[i] < b_pr[best] ||
            (b_pr[i] == b_pr[best] && b_tt[i] < b_tt[best])) begin
          best = i;
          found = 1'b1;
        end
      end
    end
    if (!found) return '0;
    if (m == 2'd0)      hy = !b_priv_user[best];
    else if (m == 2'd1) hy = !b_priv_sup[best];
    else                hy = 1'b1;
    return {1'b1, b_tt[best], b_pr[best], hy};
  endfunction

  task automatic chk(input string tag, input logic [22:0] exp);
    logic [22:0] got;
    got = {valid_o, ttype_o, prio_o, hyper_o};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got v=%0b tt=%03h pr=%0d hy=%0b expected v=%0b tt=%03h pr=%0d hy=%0b",
               tag, got[22], got[21:13], got[12:1], got[0],
               exp[22], exp[21:13], exp[12:1], exp[0]);
    end
  endtask

  task automatic apply(input logic [NT-1:0] r, input logic [1:0] m);
    @(negedge clk);
    req_i  = r;
    mode_i = m;
    @(negedge clk);
  endtask

  task automatic run_one(input string tag, input logic [NT-1:0] r, input logic [1:0] m);
    apply(r, m);
    chk(tag, expect_of(r, m));
  endtask

  task automatic t_reset_state();
    req_i = '1;
    #(CLK_PERIOD);
    chk("R9 reset holds zero", '0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_idle();
    run_one("R2 idle", '0, 2'd0);
    run_one("R2 idle hyper", '0, 2'd2);
  endtask

  task automatic t_table();
    for (int i = 0; i < NT; i++) begin
      for (int m = 0; m < 4; m++) begin
        run_one("R5 R8 single row", NT'(1) << i, 2'(m));
      end
    end
  endtask

  task automatic t_resets();
    run_one("R6 ext beats wdog/sw", 18'b1110, 2'd0);
    run_one("R6 wdog beats sw", 18'b1010, 2'd1);
    run_one("R6 power-on beats all", '1, 2'd2);
    chk("R6 power-on code", {1'b1, 9'h001, 12'd0, 1'b1});
  endtask

  task automatic t_order();
    run_one("R3 illegal over privop", 18'h00030, 2'd0);
    run_one("R3 fpdis over spill", 18'h02040, 2'd0);
    run_one("R3 spill over cleanwin", 18'h02080, 2'd1);
    run_one("R3 interrupt over trap instr", 18'h21000, 2'd0);
    chk("R3 interrupt code", {1'b1, 9'h041, 12'd1600, 1'b0});
  endtask

  task automatic t_ties();
    run_one("R4 cleanwin over misaligned", 18'h00180, 2'd0);
    chk("R4 cleanwin code", {1'b1, 9'h024, 12'd1010, 1'b0});
    run_one("R4 lowest misaligned", 18'h00F00, 2'd0);
    chk("R4 misaligned code", {1'b1, 9'h035, 12'd1010, 1'b1});
    run_one("R4 spill other over fills", 18'h1C000, 2'd1);
    run_one("R4 spill normal first", 18'h1E000, 2'd0);
    chk("R4 spill code", {1'b1, 9'h080, 12'd900, 1'b0});
  endtask

  task automatic t_levels();
    run_one("R7 privop from user", 18'h00020, 2'd0);
    chk("R7 privop user level", {1'b1, 9'h011, 12'd700, 1'b0});
    run_one("R7 privop from priv", 18'h00020, 2'd1);
    chk("R7 privop priv level", {1'b1, 9'h011, 12'd700, 1'b1});
    run_one("R8 code 3 is hyper", 18'h20000, 2'd3);
    chk("R8 trap instr hyper", {1'b1, 9'h100, 12'd1602, 1'b1});
  endtask

  task automatic t_latency();
    logic [22:0] old_exp;
    apply(18'h00010, 2'd0);
    old_exp = expect_of(18'h00010, 2'd0);
    @(negedge clk);
    req_i = 18'h10000;
    #1;
    chk("R9 stable before edge", old_exp);
    @(negedge clk);
    chk("R9 updated after edge", expect_of(18'h10000, 2'd0));
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R9 async reset clears", '0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_random();
    logic [NT-1:0] r;
    for (int k = 0; k < 300; k++) begin
      r = NT'($urandom());
      if (k % 3 == 0) r = r & NT'($urandom()) & NT'($urandom());
      run_one("R1 R3 random", r, 2'($urandom()));
    end
  endtask

  initial begin
    b_tt = '{9'h001, 9'h002, 9'h003, 9'h004, 9'h010, 9'h011, 9'h020, 9'h024, 9'h035,
             9'h036, 9'h038, 9'h039, 9'h041, 9'h080, 9'h0A0, 9'h0C0, 9'h0E0, 9'h100};
    b_pr = '{12'd0, 12'd120, 12'd110, 12'd130, 12'd620, 12'd700, 12'd800, 12'd1010, 12'd1010,
             12'd1010, 12'd1010, 12'd1010, 12'd1600, 12'd900, 12'd900, 12'd900, 12'd900, 12'd1602};
    for (int i = 0; i < NT; i++) begin
      b_priv_sup[i]  = (i == 6 || i == 7 || i >= 12);
      b_priv_user[i] = b_priv_sup[i] || (i == 5);
    end
    t_reset_state();
    t_idle();
    t_table();
    t_resets();
    t_order();
    t_ties();
    t_levels();
    t_latency();
    t_random();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule